// File: doc/BRIEF.md
# Board Status and Control Register Bank

This block is the software-visible register file of a multi-channel pulse converter board. It sits behind a simple synchronous bus: a byte address, a write strobe with 32-bit write data, and a read strobe whose 32-bit result appears in the following cycle. It holds four registers. The first is a constant board identifier. The second is a status word that combines the gateware version, the on-board switches, the rear-module detection lines and a set of sticky error flags. The third is a control word that guards a soft reset behind an unlock bit. The fourth is a live snapshot of the front, inverted and rear input lines and of the no-signal detectors.

Hardware raises the sticky flags with single-cycle event inputs: an I2C watchdog timeout, an I2C addressing error, and one pulse-missed event per channel. Software clears a flag by writing 1 to its bit. The line inputs are asynchronous, so each passes through a two-flop synchronizer before it can be read. A soft reset that is accepted drives `softRstReq` high for exactly one cycle.

Top module: `board_regs`

## Requirements
- R1: A read of byte offset 0x00 returns 0x54424C4F, and writes to that offset change nothing that can be read back.
- R2: A read of offset 0x04 returns the gateware version in [7:0], the switches in [15:8], the rear detect lines in [21:16] and timing-network-present in bit 23. All of these are taken live from the inputs. The version byte is passed through unchanged; for example 0x2E means release 2.14.
- R3: A pulse on `i2cWdtoEvt` sets status bit 22 and a pulse on `i2cErrEvt` sets status bit 24. A pulse on `pulseMissEvt[n]` sets status bit 25+n. Each flag becomes visible to a read issued in the cycle after the event and stays set after the event ends.
- R4: A write to offset 0x04 clears each sticky flag whose data bit (22, 24 or 30:25) is 1. Flags whose data bit is 0 are left unchanged, and the non-sticky fields cannot be written.
- R5: If an event and a write-1 clear hit the same sticky flag in the same cycle, the flag ends up set.
- R6: Control offset 0x08 holds the unlock bit in bit 0, which is read/write and resets to 0. The reset bit, bit 1, always reads 0.
- R7: A write to 0x08 with bit 1 set raises `softRstReq` for exactly one cycle, in the cycle after the write, but only if bit 0 was already 1 before that write. Otherwise no pulse is issued, although bit 0 still takes the written value.
- R8: Offset 0x88 returns front inputs in [5:0], inverted inputs in [9:6], rear inputs in [15:10] and no-signal flags in [21:16]. An input change that is set up before clock edge k shows in read data captured at edge k+2 and later, never earlier.
- R9: Reads of unmapped offsets return 0, and unused bits of mapped registers read 0.
- R10: `busRdata` is loaded on the edge that samples `busRe` high and holds its value while `busRe` is low. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| gwVersion | input | 8 | Gateware version, major.minor nibbles |
| switches | input | 8 | On-board switch states, 1 = on |
| rearDetect | input | 6 | Rear module detection lines |
| tnetPresent | input | 1 | Timing network present |
| i2cWdtoEvt | input | 1 | I2C watchdog timeout event |
| i2cErrEvt | input | 1 | I2C addressing error event |
| pulseMissEvt | input | 6 | Per-channel pulse-during-rejection event |
| lineFront | input | 6 | Front channel input states (asynchronous) |
| lineInv | input | 4 | Inverted-input states (asynchronous) |
| lineRear | input | 6 | Rear input states (asynchronous) |
| lineNoSig | input | 6 | No-signal detect flags (asynchronous) |
| softRstReq | output | 1 | One-cycle soft reset request |

## Verification
The bench sends an event and a write-1 clear to the same flag in the same cycle. A design where the clear wins would read that flag back as 0. It also clears one pulse-missed flag while a neighbouring flag is set, which exposes a design that clears on writes of 0 or clears the whole field. The soft reset is tried first with the unlock bit clear in the same write and then with it already set, so a design that samples the unlock bit after the write would pulse too early, and one that holds the request would show it for two cycles. Line inputs are read at two cycles and again at three cycles after a change, which catches a synchronizer that is too short or missing.

// File: rtl/board_regs_pkg.sv
package board_regs_pkg;
  localparam int DATA_W = 32;
  localparam int CH_N   = 6;
  localparam int SW_N   = 8;
  localparam int VER_W  = 8;
  localparam int INV_N  = 4;
  localparam int LINE_W = 3 * CH_N + INV_N;

  localparam logic [DATA_W-1:0] BOARD_ID = 32'h54424C4F;

  localparam int OFF_ID   = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_LINE = 'h88;

  localparam int STAT_WDTO_BIT = 22;
  localparam int STAT_TNET_BIT = 23;
  localparam int STAT_ERR_BIT  = 24;
  localparam int STAT_MISS_LSB = 25;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ID, SEL_STAT, SEL_CTRL, SEL_LINE
  } rdSel_e;

  typedef struct packed {
    logic   wrStat;
    logic   wrCtrl;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/board_regs_decode.sv
module board_regs_decode
  import board_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output regStrobe_t        strobe
);
  logic hitId, hitStat, hitCtrl, hitLine;

  always_comb begin
    hitId   = (busAddr == ADDR_W'(OFF_ID));
    hitStat = (busAddr == ADDR_W'(OFF_STAT));
    hitCtrl = (busAddr == ADDR_W'(OFF_CTRL));
    hitLine = (busAddr == ADDR_W'(OFF_LINE));

    strobe.wrStat = busWe && hitStat;
    strobe.wrCtrl = busWe && hitCtrl;
    strobe.rdEn   = busRe;
    if (hitId)        strobe.rdSel = SEL_ID;
    else if (hitStat) strobe.rdSel = SEL_STAT;
    else if (hitCtrl) strobe.rdSel = SEL_CTRL;
    else if (hitLine) strobe.rdSel = SEL_LINE;
    else              strobe.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/board_regs_dp.sv
module board_regs_dp
  import board_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [VER_W-1:0]  gwVersion,
  input  logic [SW_N-1:0]   switches,
  input  logic [CH_N-1:0]   rearDetect,
  input  logic              tnetPresent,
  input  logic              i2cWdtoEvt,
  input  logic              i2cErrEvt,
  input  logic [CH_N-1:0]   pulseMissEvt,
  input  logic [LINE_W-1:0] lineRaw,
  output logic [DATA_W-1:0] busRdata,
  output logic              softRstReq,
  output logic              unlockQ,
  output logic              wdtoQ,
  output logic              errQ,
  output logic [CH_N-1:0]   missQ
);
  localparam int STAT_USED = STAT_MISS_LSB + CH_N;

  // line synchronizer chain
  logic [SYNC_STAGES-1:0][LINE_W-1:0] syncQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= lineRaw;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  // sticky flags: event set dominates write-1 clear
  logic              clrWdto, clrErr;
  logic [CH_N-1:0]   clrMiss;

  always_comb begin
    clrWdto = strobe.wrStat && busWdata[STAT_WDTO_BIT];
    clrErr  = strobe.wrStat && busWdata[STAT_ERR_BIT];
    clrMiss = strobe.wrStat ? busWdata[STAT_MISS_LSB +: CH_N] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtoQ <= 1'b0;
      errQ  <= 1'b0;
      missQ <= '0;
    end else begin
      wdtoQ <= i2cWdtoEvt | (wdtoQ & ~clrWdto);
      errQ  <= i2cErrEvt  | (errQ  & ~clrErr);
      missQ <= pulseMissEvt | (missQ & ~clrMiss);
    end
  end

  // control: unlock bit and guarded soft reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ    <= 1'b0;
      softRstReq <= 1'b0;
    end else begin
      softRstReq <= strobe.wrCtrl && busWdata[1] && unlockQ;
      if (strobe.wrCtrl) unlockQ <= busWdata[0];
    end
  end

  // read mux
  logic [DATA_W-1:0] statWord, lineWord, rdNext;

  always_comb begin
    statWord = '0;
    statWord[VER_W-1:0]                  = gwVersion;
    statWord[VER_W +: SW_N]              = switches;
    statWord[VER_W + SW_N +: CH_N]       = rearDetect;
    statWord[STAT_WDTO_BIT]              = wdtoQ;
    statWord[STAT_TNET_BIT]              = tnetPresent;
    statWord[STAT_ERR_BIT]               = errQ;
    statWord[STAT_MISS_LSB +: CH_N]      = missQ;
    statWord[DATA_W-1:STAT_USED]         = '0;

    lineWord = '0;
    lineWord[LINE_W-1:0] = syncQ[SYNC_STAGES-1];

    unique case (strobe.rdSel)
      SEL_ID:   rdNext = BOARD_ID;
      SEL_STAT: rdNext = statWord;
      SEL_CTRL: rdNext = {{(DATA_W-1){1'b0}}, unlockQ};
      SEL_LINE: rdNext = lineWord;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdNext;
  end
endmodule

// File: rtl/board_regs.sv
module board_regs
  import board_regs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  input  logic              busRe,
  output logic [31:0]       busRdata,
  input  logic [7:0]        gwVersion,
  input  logic [7:0]        switches,
  input  logic [5:0]        rearDetect,
  input  logic              tnetPresent,
  input  logic              i2cWdtoEvt,
  input  logic              i2cErrEvt,
  input  logic [5:0]        pulseMissEvt,
  input  logic [5:0]        lineFront,
  input  logic [3:0]        lineInv,
  input  logic [5:0]        lineRear,
  input  logic [5:0]        lineNoSig,
  output logic              softRstReq
);
  regStrobe_t        strobe;
  logic              unlockQ, wdtoQ, errQ;
  logic [CH_N-1:0]   missQ;
  logic [LINE_W-1:0] lineRaw;

  assign lineRaw = {lineNoSig, lineRear, lineInv, lineFront};

  board_regs_decode #(.ADDR_W(ADDR_W)) decode_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strobe  (strobe)
  );

  board_regs_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busWdata     (busWdata),
    .gwVersion    (gwVersion),
    .switches     (switches),
    .rearDetect   (rearDetect),
    .tnetPresent  (tnetPresent),
    .i2cWdtoEvt   (i2cWdtoEvt),
    .i2cErrEvt    (i2cErrEvt),
    .pulseMissEvt (pulseMissEvt),
    .lineRaw      (lineRaw),
    .busRdata     (busRdata),
    .softRstReq   (softRstReq),
    .unlockQ      (unlockQ),
    .wdtoQ        (wdtoQ),
    .errQ         (errQ),
    .missQ        (missQ)
  );
endmodule

// File: rtl/board_regs_chk.sv
module board_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic              busRe,
  input logic [31:0]       busRdata,
  input logic              i2cErrEvt,
  input logic [5:0]        pulseMissEvt,
  input logic              softRstReq,
  input logic              unlockQ,
  input logic              errQ,
  input logic [5:0]        missQ
);
  logic mapped;
  assign mapped = (busAddr == ADDR_W'('h00)) || (busAddr == ADDR_W'('h04)) ||
                  (busAddr == ADDR_W'('h08)) || (busAddr == ADDR_W'('h88));

  a_r1_board_id: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'('h00)) |=> (busRdata == 32'h54424C4F));

  a_r3_miss_set: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseMissEvt) |=> ((missQ & $past(pulseMissEvt)) == $past(pulseMissEvt)));

  a_r5_err_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    i2cErrEvt |=> errQ);

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    (missQ & ~$past(missQ) & ~$past(pulseMissEvt)) == 6'b0);

  a_r7_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    softRstReq |=> !softRstReq);

  a_r7_needs_unlock: assert property (@(posedge clk) disable iff (!rstN)
    softRstReq |-> $past(busWe && busAddr == ADDR_W'('h08) && busWdata[1] && unlockQ));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !mapped) |=> (busRdata == 32'h0));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> $stable(busRdata));
endmodule

bind board_regs board_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .busAddr      (busAddr),
  .busWe        (busWe),
  .busWdata     (busWdata),
  .busRe        (busRe),
  .busRdata     (busRdata),
  .i2cErrEvt    (i2cErrEvt),
  .pulseMissEvt (pulseMissEvt),
  .softRstReq   (softRstReq),
  .unlockQ      (unlockQ),
  .errQ         (errQ),
  .missQ        (missQ)
);

// File: tb/board_regs_tb_top.sv
module board_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic [7:0]  gwVersion = 8'h2E;
  logic [7:0]  switches = 8'hA5;
  logic [5:0]  rearDetect = 6'h2B;
  logic        tnetPresent = 1'b1;
  logic        i2cWdtoEvt = 1'b0;
  logic        i2cErrEvt = 1'b0;
  logic [5:0]  pulseMissEvt = '0;
  logic [5:0]  lineFront = '0;
  logic [3:0]  lineInv = '0;
  logic [5:0]  lineRear = '0;
  logic [5:0]  lineNoSig = '0;
  logic        softRstReq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t expQ[$];
  logic reVld = 1'b0;

  always #2.5 clk = ~clk;

  board_regs dut_i (.*);

  // model state for expected status
  logic       mWdto = 0, mErr = 0;
  logic [5:0] mMiss = '0;

  function automatic logic [31:0] statExp();
    return {1'b0, mMiss, mErr, tnetPresent, mWdto, rearDetect, switches, gwVersion};
  endfunction

  function automatic logic [31:0] lineExp();
    return {10'b0, lineNoSig, lineRear, lineInv, lineFront};
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge
  task automatic doRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  // monitor
  always @(posedge clk) reVld <= busRe;
  always @(negedge clk) begin
    if (reVld) begin
      if (expQ.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R10: unexpected read result actual=%h expected=none", busRdata);
      end else begin
        item_t it;
        it = expQ.pop_front();
        checkVal(it.tag, busRdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R10 rdata after reset", busRdata, 32'h0);
    checkVal("R7 no pulse after reset", {31'b0, softRstReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2, R6, R8, R9 reset reads
    doRead(8'h00, 32'h54424C4F, "R1 board id");
    doRead(8'h04, statExp(), "R2 status static fields");
    doRead(8'h08, 32'h0, "R6 control reset value");
    doRead(8'h88, 32'h0, "R8 line status reset");
    doRead(8'h0C, 32'h0, "R9 unmapped 0x0C");
    doRead(8'h84, 32'h0, "R9 unmapped 0x84");
    doWrite(8'h00, 32'hFFFFFFFF);
    doRead(8'h00, 32'h54424C4F, "R1 id after write");

    // R2 live inputs
    gwVersion = 8'h11; switches = 8'h3C; rearDetect = 6'h14; tnetPresent = 1'b0;
    doRead(8'h04, statExp(), "R2 status after input change");

    // R3 sticky set
    i2cWdtoEvt = 1'b1; pulseMissEvt = 6'b001001;
    @(negedge clk);
    i2cWdtoEvt = 1'b0; pulseMissEvt = '0;
    mWdto = 1; mMiss = 6'b001001;
    doRead(8'h04, statExp(), "R3 wdto and miss set");
    i2cErrEvt = 1'b1;
    @(negedge clk);
    i2cErrEvt = 1'b0; mErr = 1;
    @(negedge clk);
    doRead(8'h04, statExp(), "R3 err held after event");

    // R4 write-1 clear, write-0 leaves
    doWrite(8'h04, 32'h0);
    doRead(8'h04, statExp(), "R4 write zero no effect");
    doWrite(8'h04, 32'h1 << 25);
    mMiss = 6'b001000;
    doRead(8'h04, statExp(), "R4 clear miss0 only");
    doWrite(8'h04, (32'h1 << 22) | 32'h00FFFFFF);
    mWdto = 0;
    doRead(8'h04, statExp(), "R4 clear wdto, static fields kept");

    // R5 set wins
    i2cErrEvt = 1'b1; pulseMissEvt = 6'b001000;
    doWrite(8'h04, (32'h1 << 24) | (32'h1 << 28));
    i2cErrEvt = 1'b0; pulseMissEvt = '0;
    doRead(8'h04, statExp(), "R5 set beats clear");
    doWrite(8'h04, 32'hFFFFFFFF);
    mErr = 0; mMiss = '0;
    doRead(8'h04, statExp(), "R4 clear all");

    // R6/R7 locked reset write
    doWrite(8'h08, 32'h3);
    checkVal("R7 no pulse when locked", {31'b0, softRstReq}, 32'h0);
    @(negedge clk);
    checkVal("R7 still no pulse", {31'b0, softRstReq}, 32'h0);
    doRead(8'h08, 32'h1, "R6 unlock stored, reset reads 0");
    doWrite(8'h08, 32'h3);
    checkVal("R7 pulse when unlocked", {31'b0, softRstReq}, 32'h1);
    @(negedge clk);
    checkVal("R7 pulse one cycle", {31'b0, softRstReq}, 32'h0);
    doWrite(8'h08, 32'h0);
    doRead(8'h08, 32'h0, "R6 unlock cleared");
    doWrite(8'h08, 32'h2);
    checkVal("R7 no pulse after relock", {31'b0, softRstReq}, 32'h0);

    // R8 synchronizer depth
    begin
      logic [31:0] oldL;
      oldL = lineExp();
      lineFront = 6'h15; lineInv = 4'hA; lineRear = 6'h33; lineNoSig = 6'h0F;
      doRead(8'h88, oldL, "R8 old at edge k");
      doRead(8'h88, oldL, "R8 old at edge k+1");
      doRead(8'h88, lineExp(), "R8 new at edge k+2");
    end
    lineFront = 6'h3F; lineInv = 4'h0; lineRear = 6'h00; lineNoSig = 6'h30;
    repeat (3) @(negedge clk);
    doRead(8'h88, lineExp(), "R8 second pattern");

    // R10 hold
    repeat (2) @(negedge clk);
    checkVal("R10 rdata holds", busRdata, lineExp());
    repeat (2) @(negedge clk);

    finished = 1;
    if (expQ.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R10: pending reads actual=%0d expected=0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule